// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes. The host offers one read or one write at a time over a request/ready handshake. The controller registers the address and the write data, then plays out a sequence of active-low chip-select, write-enable and output-enable strobes. Each phase of that sequence lasts at least the memory's minimum timing interval.

Every interval is given in nanoseconds as a parameter. Each one is turned into a whole number of clock cycles by rounding up, with a floor of one cycle. The controller drives the shared data bus only during a write. It captures read data once both the address-access window and the output-enable-access window have elapsed. It pulses a one-cycle read-valid with the byte. A read that follows a write gets an extra turnaround phase, so the controller's drivers and the memory's drivers are never on at the same time.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, all three strobes are high, the bus driver enable is low, ready is high and read-valid is low.
- R2: A request is taken only on a clock edge where both request and ready are high. Ready is low in the cycle after acceptance and stays low until the operation ends. Each accepted request produces exactly one strobe sequence, and no strobe is active while ready is high.
- R3: A write holds chip select and write enable low together for exactly NWP cycles, with output enable high. NWP is the largest of the rounded write-pulse, address-valid, chip-enable-to-end and data-setup intervals, which is 3 with the default parameters.
- R4: A write keeps ready low for NWP + NWR cycles. NWR is the rounded write cycle minus NWP, with a floor of 1, and is 1 with the defaults.
- R5: The bus driver enable is high only during a write's pulse and recovery phases, and never while output enable is low. The driven data is constant while write enable is low, and that data is the byte stored at the write address.
- R6: A read holds chip select and output enable low with write enable high for exactly NRD cycles. NRD is the largest of the rounded address-access, chip-enable-access and output-enable-access intervals, which is 4 with the defaults. The bus is sampled on the edge that ends this phase, and read-valid is high for exactly one cycle with that byte.
- R7: A read keeps ready low for NRD + NRR cycles, plus NTA if the previously accepted request was a write. NRR is the largest of (rounded read cycle minus NRD), the rounded output-disable-to-high-impedance interval and 1, which is 2 with the defaults. The controller never drives the bus while the memory may still be driving it.
- R8: Between the last cycle with the bus driver enabled and the first cycle with output enable low, there are at least NTA + 1 cycles with both off. NTA is the turnaround parameter, with a floor of 1.
- R9: The memory address is loaded only on acceptance. It stays stable for as long as chip select is low and until the next acceptance.
- R10: Write enable and output enable are never low together, and either of them low implies that chip select is low.
- R11: Every interval count equals the ceiling of its nanosecond value divided by the clock period, and is never less than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the request |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller idle, request may be taken |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| mem_addr | output | 19 | Address to the memory |
| mem_dq_out | output | 8 | Data towards the memory |
| mem_dq_oe | output | 1 | Enable of the controller's bus driver |
| mem_dq_in | input | 8 | Data seen on the bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The bench's memory model returns the inverted byte until both the address and the output-enable access windows have passed. A controller that samples one cycle early therefore returns wrong data and fails the scoreboard. The model also keeps driving the bus for the high-impedance delay after output enable rises, and it flags any cycle in which it and the controller drive together. This catches a missing turnaround after a write, or a recovery that is too short before a write that follows a read. Write-pulse and read-phase lengths and ready-low counts are measured for every pattern (write after write, read after write with and without idle gaps, read after read, write after read). A wrong cycle rounding or a dropped phase shows up as a length mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_TURN,
        ST_RD_ACCESS,
        ST_RD_RECOV
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    // ceiling of ns / clk_ns, never below one cycle
    function automatic int ns_to_cyc(int ns, int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(phase_e p);
        strobe_t s;
        s = STROBE_IDLE;
        case (p)
            ST_WR_PULSE: begin
                s.cs_n  = 1'b0;
                s.we_n  = 1'b0;
                s.drive = 1'b1;
            end
            ST_WR_RECOV: s.drive = 1'b1;
            ST_RD_ACCESS: begin
                s.cs_n = 1'b0;
                s.oe_n = 1'b0;
            end
            default: s = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_STAYS_DONE: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired); // R11

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int N_WP  = 3,
    parameter int N_WR  = 1,
    parameter int N_RD  = 4,
    parameter int N_RR  = 2,
    parameter int N_TA  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_we,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output phase_e           phase_d,
    output logic             accept,
    output logic             capture,
    output logic             ready
);

    localparam logic [CNT_W-1:0] LD_WP = CNT_W'(N_WP - 1);
    localparam logic [CNT_W-1:0] LD_WR = CNT_W'(N_WR - 1);
    localparam logic [CNT_W-1:0] LD_RD = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] LD_RR = CNT_W'(N_RR - 1);
    localparam logic [CNT_W-1:0] LD_TA = CNT_W'(N_TA - 1);

    phase_e phase_q;
    logic   last_wr_q;

    assign ready  = (phase_q == ST_IDLE);
    assign accept = req && ready;

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (phase_q)
            ST_IDLE: begin
                if (req) begin
                    tmr_load = 1'b1;
                    if (req_we) begin
                        phase_d = ST_WR_PULSE;
                        tmr_val = LD_WP;
                    end else if (last_wr_q) begin
                        phase_d = ST_RD_TURN;
                        tmr_val = LD_TA;
                    end else begin
                        phase_d = ST_RD_ACCESS;
                        tmr_val = LD_RD;
                    end
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    phase_d  = ST_WR_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WR;
                end
            end
            ST_WR_RECOV: begin
                if (tmr_expired) phase_d = ST_IDLE;
            end
            ST_RD_TURN: begin
                if (tmr_expired) begin
                    phase_d  = ST_RD_ACCESS;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RD;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    phase_d  = ST_RD_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RR;
                    capture  = 1'b1;
                end
            end
            ST_RD_RECOV: begin
                if (tmr_expired) phase_d = ST_IDLE;
            end
            default: phase_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= ST_IDLE;
            last_wr_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept) last_wr_q <= req_we;
        end
    end

    AST_CAPTURE_ENDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        capture |=> (phase_q == ST_RD_RECOV)); // R6
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready); // R2
    AST_TURN_BEFORE_READ: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_RD_ACCESS && $past(phase_q) == ST_IDLE) |-> !$past(last_wr_q)); // R8

endmodule

// File: rtl/sram_bus_io.sv
module sram_bus_io
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int N_WP   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_d,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int WLC_W = $clog2(N_WP + 1) + 1;
    localparam logic [WLC_W-1:0] WLC_MAX = WLC_W'(N_WP);

    strobe_t st_q;
    logic [WLC_W-1:0] we_low_cnt;

    // strobes come straight from flops so the memory sees no decode glitches
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= STROBE_IDLE;
        end else begin
            st_q <= strobes_for(phase_d);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= host_addr;
            mem_dq_out <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= mem_dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt <= '0;
        end else if (!st_q.we_n) begin
            if (we_low_cnt != WLC_MAX) we_low_cnt <= we_low_cnt + 1'b1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    assign mem_cs_n  = st_q.cs_n;
    assign mem_we_n  = st_q.we_n;
    assign mem_oe_n  = st_q.oe_n;
    assign mem_dq_oe = st_q.drive;

    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_oe_n) |-> !mem_cs_n); // R10
    AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n); // R10
    AST_DRIVE_NOT_READING: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n); // R5
    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R9
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out)); // R5
    AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cnt >= WLC_MAX)); // R3
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R6

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 4,
    parameter int WC_NS    = 15,
    parameter int WP_NS    = 10,
    parameter int AW_NS    = 10,
    parameter int CW_NS    = 10,
    parameter int DS_NS    = 8,
    parameter int RC_NS    = 15,
    parameter int AA_NS    = 15,
    parameter int ACS_NS   = 15,
    parameter int OE_NS    = 7,
    parameter int OHZ_NS   = 7,
    parameter int TURN_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);

    localparam int N_WP = imax(imax(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(AW_NS, CLK_NS)),
                               imax(ns_to_cyc(CW_NS, CLK_NS), ns_to_cyc(DS_NS, CLK_NS)));
    localparam int N_WR = imax(1, ns_to_cyc(WC_NS, CLK_NS) - N_WP);
    localparam int N_RD = imax(imax(ns_to_cyc(AA_NS, CLK_NS), ns_to_cyc(ACS_NS, CLK_NS)),
                               ns_to_cyc(OE_NS, CLK_NS));
    localparam int N_RR = imax(imax(1, ns_to_cyc(RC_NS, CLK_NS) - N_RD),
                               ns_to_cyc(OHZ_NS, CLK_NS));
    localparam int N_TA = imax(1, TURN_CYC);
    localparam int N_MAX = imax(imax(N_WP, N_WR), imax(imax(N_RD, N_RR), N_TA));
    localparam int CNT_W = $clog2(N_MAX + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    phase_e           phase_d;
    logic             accept;
    logic             capture;

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctrl_fsm #(
        .CNT_W (CNT_W),
        .N_WP  (N_WP),
        .N_WR  (N_WR),
        .N_RD  (N_RD),
        .N_RR  (N_RR),
        .N_TA  (N_TA)
    ) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .req_we      (req_we),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .phase_d     (phase_d),
        .accept      (accept),
        .capture     (capture),
        .ready       (ready)
    );

    sram_bus_io #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_WP   (N_WP)
    ) io_i (
        .clk        (clk),
        .rst        (rst),
        .phase_d    (phase_d),
        .accept     (accept),
        .capture    (capture),
        .host_addr  (req_addr),
        .host_wdata (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

endmodule

// File: tb/sram_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_tb_top;

    localparam int TCLK = 4;

    function automatic int up(int ns);
        int c;
        c = (ns + TCLK - 1) / TCLK;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // expected counts from R3, R4, R6, R7, R8, R11 with default timings
    localparam int E_WP  = mx(mx(up(10), up(10)), mx(up(10), up(8)));
    localparam int E_WR  = mx(1, up(15) - E_WP);
    localparam int E_RD  = mx(mx(up(15), up(15)), up(7));
    localparam int E_RR  = mx(mx(1, up(15) - E_RD), up(7));
    localparam int E_TA  = 1;
    localparam int E_OHZ = up(7);
    localparam int M_AA  = up(15);
    localparam int M_OE  = up(7);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic ready, rd_valid, mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n;
    logic [7:0]  rd_data, mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;
    logic [18:0] mem_addr;

    always #(TCLK/2) clk = ~clk;

    sram_strobe_ctrl dut_i (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    int total = 0, bad = 0;
    bit finished = 1'b0;

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bg(logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    logic [7:0] mem [int];
    logic [7:0] shadow [int];
    logic [7:0] expq [$];

    function automatic logic [7:0] mem_rd(logic [18:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : bg(a);
    endfunction

    // memory model and monitor, sampled away from the active edge
    int oe_cnt = 0, aa_cnt = 0, hz_cnt = 0, gap = 100;
    int we_run = 0, oe_run = 0, wr_pulses = 0, rd_pulses = 0, rv_count = 0;
    bit pwe = 1'b0, poe = 1'b1, m_act, m_drive;
    logic [18:0] pa = '0, pw_a = '0;
    logic [7:0]  pw_d = '0;

    always @(negedge clk) begin
        if (!rst) begin
            m_act = !mem_cs_n && !mem_oe_n && mem_we_n;
            if (m_act) begin
                oe_cnt++;
                hz_cnt = E_OHZ;
            end else begin
                oe_cnt = 0;
                if (hz_cnt > 0) hz_cnt--;
            end
            m_drive = m_act || (hz_cnt > 0);
            if (mem_cs_n) aa_cnt = 0;
            else if (mem_addr != pa) aa_cnt = 1;
            else aa_cnt++;
            if (!mem_cs_n && !poe && mem_addr != pa) chk(0, "R9 address moved during read", int'(mem_addr), int'(pa));
            pa = mem_addr;
            mem_dq_in = (m_act && oe_cnt >= M_OE && aa_cnt >= M_AA) ? mem_rd(mem_addr) : ~mem_rd(mem_addr);
            if (m_drive && mem_dq_oe) chk(0, "R7 R8 bus contention", 1, 0);
            // turnaround gap
            if (poe && !mem_oe_n) chk(gap >= E_TA + 1, "R8 turnaround gap", gap, E_TA + 1);
            if (mem_dq_oe) gap = 0;
            else if (mem_oe_n && gap < 100) gap++;
            poe = mem_oe_n;
            // write commit at rising write enable
            if (pwe && mem_we_n) begin
                mem[int'(pw_a)] = pw_d;
                wr_pulses++;
            end
            if (!mem_we_n) begin
                if (pwe && (mem_dq_out != pw_d || mem_addr != pw_a))
                    chk(0, "R5 R9 write data/address moved", int'(mem_dq_out), int'(pw_d));
                if (!mem_dq_oe) chk(0, "R5 bus not driven in write pulse", 0, 1);
                pw_a = mem_addr;
                pw_d = mem_dq_out;
            end
            pwe = !mem_we_n;
            // phase lengths
            if (!mem_we_n) we_run++;
            else if (we_run > 0) begin
                chk(we_run == E_WP, "R3 write pulse length", we_run, E_WP);
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (oe_run > 0) begin
                chk(oe_run == E_RD, "R6 read phase length", oe_run, E_RD);
                rd_pulses++;
                oe_run = 0;
            end
            // invariants
            if ((!mem_we_n || !mem_oe_n) && mem_cs_n) chk(0, "R10 strobe without chip select", 1, 0);
            if (!mem_we_n && !mem_oe_n) chk(0, "R10 write and output enable both low", 1, 0);
            if (mem_dq_oe && !mem_oe_n) chk(0, "R5 driving while output enabled", 1, 0);
            if (ready && !mem_cs_n) chk(0, "R2 strobe while ready", 1, 0);
            // scoreboard
            if (rd_valid) begin
                rv_count++;
                if (expq.size() == 0) chk(0, "R6 unexpected read-valid", int'(rd_data), -1);
                else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    chk(rd_data == e, "R6 read data", int'(rd_data), int'(e));
                end
            end
        end
    end

    bit last_w = 1'b0;
    int n_wr = 0, n_rd = 0;

    // caller is at a negedge
    task automatic issue(bit w, logic [18:0] a, logic [7:0] d);
        int busy, exp_busy;
        while (!ready) @(negedge clk);
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
        if (w) begin
            shadow[int'(a)] = d;
            n_wr++;
            exp_busy = E_WP + E_WR;
        end else begin
            expq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : bg(a));
            n_rd++;
            exp_busy = (last_w ? E_TA : 0) + E_RD + E_RR;
        end
        @(negedge clk);
        req = 1'b0;
        chk(!ready, "R2 ready drops after accept", int'(ready), 0);
        busy = 0;
        while (!ready && busy < 1000) begin
            busy++;
            @(negedge clk);
        end
        if (w) chk(busy == exp_busy, "R4 R11 write busy cycles", busy, exp_busy);
        else   chk(busy == exp_busy, "R7 R11 read busy cycles", busy, exp_busy);
        last_w = w;
    endtask

    task automatic r1_check(string tag);
        chk(mem_cs_n && mem_we_n && mem_oe_n, {tag, " strobes high"}, int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
        chk(!mem_dq_oe, {tag, " driver off"}, int'(mem_dq_oe), 0);
        chk(ready && !rd_valid, {tag, " ready/valid"}, int'({ready, rd_valid}), 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        r1_check("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        r1_check("R1 after reset");

        issue(1, 19'h00000, 8'h11);
        issue(0, 19'h00000, 8'h00);      // read after write, turnaround
        issue(0, 19'h7FFFF, 8'h00);      // read after read, unwritten
        issue(1, 19'h7FFFF, 8'hFF);      // write after read
        issue(1, 19'h12345, 8'h00);      // write after write
        repeat (5) @(negedge clk);
        issue(0, 19'h12345, 8'h00);      // read after write with idle gap
        issue(0, 19'h7FFFF, 8'h00);
        issue(1, 19'h00005, 8'hA5);
        issue(0, 19'h00005, 8'h00);
        issue(0, 19'h00000, 8'h00);
        for (int i = 0; i < 24; i++) begin
            logic [18:0] a;
            a = 19'((i % 5) * 19'h1F3D1);
            issue((i % 3) != 0, a, 8'(i * 37 + 3));
        end
        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R6 all reads answered", expq.size(), 0);
        chk(rv_count == n_rd, "R6 one valid per read", rv_count, n_rd);
        chk(wr_pulses == n_wr, "R2 one write pulse per write", wr_pulses, n_wr);
        chk(rd_pulses == n_rd, "R2 one read phase per read", rd_pulses, n_rd);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule